// File: doc/BRIEF.md
# PCM Voice Serial Port

This block moves one 16-bit voice slot per frame between parallel sample registers and a serial PCM data line. A bit clock and a frame sync are taken either from an on-chip generator, supplied on the `int_*` inputs, or from external pins. All of them are oversampled in the system clock domain. Every transmit bit is launched on a rising bit-clock edge. Every receive bit is captured on a falling bit-clock edge.

Static inputs set the following:
- the timing source
- the frame-sync style
- the sample width
- how narrow samples fill the slot
- the bit order
- the tri-state policy of the data output
- a mute

A narrow transmit sample can be placed in the top of the slot. In that case a 13-bit sample carries the 3-bit gain value in its low bits, and an 8-bit sample carries zeros below it. Otherwise the narrow sample is sign-extended to 16 bits. In receive, the same setting is undone, and a sign-extended 16-bit sample is returned with a one-cycle valid strobe.

Top module: `pcm_voice_port`

## Requirements
- R1: With `slave_i`=0 the bit clock and sync come from `int_bclk_i`/`int_sync_i`. With `slave_i`=1 they come from `pcm_clk_i`/`pcm_sync_i`. The unselected pair has no effect.
- R2: A frame start is detected at a rising bit-clock edge under two conditions. With `short_sync_i`=0, the sync is high there and was low at the previous rising edge. With `short_sync_i`=1, it is low there and was high at the previous rising edge. Slot bit 0 is driven at the next rising edge, and bits 1..15 follow at the consecutive rising edges.
- R3: Padding (`sign_ext_i`=0) fills the slot according to `width_i`. For 13 bits (`width_i`=1), the slot is {sample[12:0], gain[2:0]}. For 8 bits (`width_i`=2), it is {sample[7:0], 8'h00}. For `width_i`=0 or 3, the slot is the full 16-bit sample.
- R4: Sign extension (`sign_ext_i`=1) puts the narrow sample in the low bits and fills the bits above it with copies of its sign bit.
- R5: With `lsb_first_i`=0, slot bit 15 is sent and received first. With `lsb_first_i`=1, slot bit 0 goes first, in both directions.
- R6: With `tri_en_i`=0, `pcm_oe_o` is 1 at all times. With `tri_en_i`=1, it is 0 before the first slot and 1 from the rising edge that drives bit 0 through the last bit.
- R7: When `tri_en_i`=1 and no new slot is pending, the output enable is released after the last bit. With `tri_late_i`=0, it drops after the falling edge inside bit 15. With `tri_late_i`=1, it drops after the following rising edge. When a new slot is pending, it stays asserted across the boundary.
- R8: `mute_i`=1 holds `pcm_out_o` at 0 and leaves the slot timing and output enable unchanged.
- R9: After the falling edge of bit 15, `rx_sample_o` holds the received sample decoded by the current width and fill settings and sign-extended to 16 bits. `rx_valid_o` pulses high for exactly one clock per frame.
- R10: `pcm_out_o` is 0 outside an active slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_i | input | 1 | 0: on-chip timing, 1: external timing |
| short_sync_i | input | 1 | 0: sync rise starts frame, 1: sync fall starts frame |
| width_i | input | 2 | Sample width: 0=16, 1=13, 2=8, 3=16 |
| sign_ext_i | input | 1 | 0: pad narrow samples, 1: sign-extend |
| lsb_first_i | input | 1 | Serial bit order |
| tri_en_i | input | 1 | Release data output between slots |
| tri_late_i | input | 1 | Release after next rising edge instead of last falling edge |
| mute_i | input | 1 | Force data output low |
| tx_sample_i | input | 16 | Transmit sample, narrow widths in low bits |
| tx_gain_i | input | 3 | Gain bits used in 13-bit padding |
| rx_sample_o | output | 16 | Received sample, sign-extended |
| rx_valid_o | output | 1 | One-cycle strobe per received frame |
| int_bclk_i | input | 1 | On-chip generated bit clock |
| int_sync_i | input | 1 | On-chip generated frame sync |
| pcm_clk_i | input | 1 | External bit clock |
| pcm_sync_i | input | 1 | External frame sync |
| pcm_in_i | input | 1 | Serial receive data |
| pcm_out_o | output | 1 | Serial transmit data |
| pcm_oe_o | output | 1 | Output enable for the transmit data |

## Verification
The bench sweeps the three widths, both fill modes, both bit orders and both sync styles in every combination. It alternates the timing source and the release timing across the sweep, and computes the expected slot word and the decoded receive value arithmetically. Transmit and receive samples are chosen so that both signs occur, which separates sign extension from zero fill and shows whether the gain bits land in place. Dedicated frames cover three further cases: mute, an output enable that is never released, and two slots sent back to back. The back-to-back frames show whether the enable is wrongly dropped when the next slot follows at once.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int SLOT_W = 16;
  localparam int GAIN_W = 3;

  typedef enum logic [1:0] {
    SW_16 = 2'd0,
    SW_13 = 2'd1,
    SW_8  = 2'd2,
    SW_16B = 2'd3
  } samp_w_e;

  // parallel sample -> slot word
  function automatic logic [SLOT_W-1:0] fmt_slot(logic [SLOT_W-1:0] s, logic [GAIN_W-1:0] g,
                                                  samp_w_e w, logic sext);
    case (w)
      SW_13:   return sext ? {{3{s[12]}}, s[12:0]} : {s[12:0], g};
      SW_8:    return sext ? {{8{s[7]}}, s[7:0]} : {s[7:0], 8'h00};
      default: return s;
    endcase
  endfunction

  // slot word -> sign-extended sample
  function automatic logic [SLOT_W-1:0] unfmt_slot(logic [SLOT_W-1:0] x, samp_w_e w, logic sext);
    case (w)
      SW_13:   return sext ? {{3{x[12]}}, x[12:0]} : {{3{x[15]}}, x[15:3]};
      SW_8:    return sext ? {{8{x[7]}}, x[7:0]} : {{8{x[15]}}, x[15:8]};
      default: return x;
    endcase
  endfunction
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
  parameter int SLOT_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(SLOT_W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_i,
  input  logic short_sync_i,
  input  logic int_bclk_i,
  input  logic int_sync_i,
  input  logic ext_bclk_i,
  input  logic ext_sync_i,
  input  logic din_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic active_o,
  output logic last_o,
  output logic pending_o,
  output logic din_o
);
  logic [SYNC_STAGES-1:0] clk_ff, sync_ff, din_ff;
  logic clk_d, sync_prev, pending_q, active_q;
  logic [IDX_W-1:0] idx_q;
  logic bclk_s, sync_s, start_det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_ff  <= '0;
      sync_ff <= '0;
      din_ff  <= '0;
      clk_d   <= 1'b0;
    end else begin
      clk_ff  <= {clk_ff[SYNC_STAGES-2:0], slave_i ? ext_bclk_i : int_bclk_i};
      sync_ff <= {sync_ff[SYNC_STAGES-2:0], slave_i ? ext_sync_i : int_sync_i};
      din_ff  <= {din_ff[SYNC_STAGES-2:0], din_i};
      clk_d   <= clk_ff[SYNC_STAGES-1];
    end
  end

  assign bclk_s    = clk_ff[SYNC_STAGES-1];
  assign sync_s    = sync_ff[SYNC_STAGES-1];
  assign rise_o    = bclk_s & ~clk_d;
  assign fall_o    = ~bclk_s & clk_d;
  assign start_det = short_sync_i ? (sync_prev & ~sync_s) : (~sync_prev & sync_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev <= 1'b0;
      pending_q <= 1'b0;
      active_q  <= 1'b0;
      idx_q     <= '0;
    end else if (rise_o) begin
      sync_prev <= sync_s;
      if (pending_q) begin
        pending_q <= 1'b0;
        active_q  <= 1'b1;
        idx_q     <= '0;
      end else begin
        if (start_det) pending_q <= 1'b1;
        if (active_q) begin
          if (idx_q == IDX_W'(SLOT_W-1)) active_q <= 1'b0;
          else idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign start_o   = rise_o & pending_q;
  assign active_o  = active_q;
  assign last_o    = active_q & (idx_q == IDX_W'(SLOT_W-1));
  assign pending_o = pending_q;
  assign din_o     = din_ff[SYNC_STAGES-1];
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              last_i,
  input  logic              pending_i,
  input  logic [1:0]        width_i,
  input  logic              sign_ext_i,
  input  logic              lsb_first_i,
  input  logic              tri_en_i,
  input  logic              tri_late_i,
  input  logic              mute_i,
  input  logic [SLOT_W-1:0] sample_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              out_o,
  output logic              oe_o
);
  logic [SLOT_W-1:0] word, sh_q;
  logic bit_q, oe_q;

  assign word = fmt_slot(sample_i, gain_i, samp_w_e'(width_i), sign_ext_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (rise_i) begin
      if (start_i) begin
        sh_q  <= word;
        bit_q <= lsb_first_i ? word[0] : word[SLOT_W-1];
        oe_q  <= 1'b1;
      end else if (active_i && !last_i) begin
        if (lsb_first_i) begin
          sh_q  <= {1'b0, sh_q[SLOT_W-1:1]};
          bit_q <= sh_q[1];
        end else begin
          sh_q  <= {sh_q[SLOT_W-2:0], 1'b0};
          bit_q <= sh_q[SLOT_W-2];
        end
      end else if (last_i) begin
        bit_q <= 1'b0;
        if (tri_late_i) oe_q <= 1'b0;
      end
    end else if (fall_i && last_i && !tri_late_i && !pending_i) begin
      oe_q <= 1'b0;
    end
  end

  assign out_o = bit_q & ~mute_i;
  assign oe_o  = ~tri_en_i | oe_q;
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              active_i,
  input  logic              last_i,
  input  logic              din_i,
  input  logic [1:0]        width_i,
  input  logic              sign_ext_i,
  input  logic              lsb_first_i,
  output logic [SLOT_W-1:0] sample_o,
  output logic              valid_o
);
  logic [SLOT_W-1:0] sh_q, sh_nxt;

  assign sh_nxt = lsb_first_i ? {din_i, sh_q[SLOT_W-1:1]} : {sh_q[SLOT_W-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (fall_i && active_i) begin
        sh_q <= sh_nxt;
        if (last_i) begin
          sample_o <= unfmt_slot(sh_nxt, samp_w_e'(width_i), sign_ext_i);
          valid_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_i,
  input  logic              short_sync_i,
  input  logic [1:0]        width_i,
  input  logic              sign_ext_i,
  input  logic              lsb_first_i,
  input  logic              tri_en_i,
  input  logic              tri_late_i,
  input  logic              mute_i,
  input  logic [SLOT_W-1:0] tx_sample_i,
  input  logic [GAIN_W-1:0] tx_gain_i,
  output logic [SLOT_W-1:0] rx_sample_o,
  output logic              rx_valid_o,
  input  logic              int_bclk_i,
  input  logic              int_sync_i,
  input  logic              pcm_clk_i,
  input  logic              pcm_sync_i,
  input  logic              pcm_in_i,
  output logic              pcm_out_o,
  output logic              pcm_oe_o
);
  logic bclk_rise, bclk_fall, slot_start, slot_active, slot_last, slot_pending, din_s;

  pcm_slot_timer #(.SLOT_W(SLOT_W), .SYNC_STAGES(SYNC_STAGES)) u_tim (
    .clk_i, .rst_ni, .slave_i, .short_sync_i,
    .int_bclk_i, .int_sync_i,
    .ext_bclk_i(pcm_clk_i), .ext_sync_i(pcm_sync_i), .din_i(pcm_in_i),
    .rise_o(bclk_rise), .fall_o(bclk_fall), .start_o(slot_start),
    .active_o(slot_active), .last_o(slot_last), .pending_o(slot_pending), .din_o(din_s)
  );

  pcm_tx_lane u_tx (
    .clk_i, .rst_ni,
    .rise_i(bclk_rise), .fall_i(bclk_fall), .start_i(slot_start),
    .active_i(slot_active), .last_i(slot_last), .pending_i(slot_pending),
    .width_i, .sign_ext_i, .lsb_first_i, .tri_en_i, .tri_late_i, .mute_i,
    .sample_i(tx_sample_i), .gain_i(tx_gain_i),
    .out_o(pcm_out_o), .oe_o(pcm_oe_o)
  );

  pcm_rx_lane u_rx (
    .clk_i, .rst_ni,
    .fall_i(bclk_fall), .active_i(slot_active), .last_i(slot_last), .din_i(din_s),
    .width_i, .sign_ext_i, .lsb_first_i,
    .sample_o(rx_sample_o), .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tri_en_i,
  input logic mute_i,
  input logic pcm_out_o,
  input logic pcm_oe_o,
  input logic rx_valid_o,
  input logic tx_rise,
  input logic slot_active,
  input logic slot_last
);
  a_r6_driven_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tri_en_i |-> pcm_oe_o);

  a_r6_driven_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_en_i && slot_active && !slot_last) |-> pcm_oe_o);

  a_r8_mute_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |-> !pcm_out_o);

  a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r9_valid_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(slot_last));

  a_r5_out_moves_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_i && $past(!mute_i) && !$stable(pcm_out_o)) |-> $past(tx_rise));

  a_r10_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_active |-> !pcm_out_o);
endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tri_en_i(tri_en_i), .mute_i(mute_i),
  .pcm_out_o(pcm_out_o), .pcm_oe_o(pcm_oe_o), .rx_valid_o(rx_valid_o),
  .tx_rise(bclk_rise), .slot_active(slot_active), .slot_last(slot_last)
);

// File: tb/sim_pcm_voice_port.sv
module sim_pcm_voice_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic slave = 1'b1, short_s = 1'b0, sext = 1'b0, lsb = 1'b0;
  logic tri_en = 1'b1, tri_late = 1'b0, mute = 1'b0;
  logic [1:0] width = 2'd0;
  logic [15:0] tx_s = '0;
  logic [2:0] gain = '0;
  logic bclk = 1'b0, sync = 1'b0, din = 1'b0;
  logic [15:0] rx_sample;
  logic rx_valid, pout, poe;

  int checks = 0, fails = 0, vcount = 0;
  logic out_r [64], oe_r [64], oe_f [64], sync_at [64], din_at [64];

  pcm_voice_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .slave_i(slave), .short_sync_i(short_s),
    .width_i(width), .sign_ext_i(sext), .lsb_first_i(lsb), .tri_en_i(tri_en),
    .tri_late_i(tri_late), .mute_i(mute), .tx_sample_i(tx_s), .tx_gain_i(gain),
    .rx_sample_o(rx_sample), .rx_valid_o(rx_valid),
    .int_bclk_i(slave ? 1'b0 : bclk), .int_sync_i(slave ? 1'b0 : sync),
    .pcm_clk_i(slave ? bclk : 1'b0), .pcm_sync_i(slave ? sync : 1'b0),
    .pcm_in_i(din), .pcm_out_o(pout), .pcm_oe_o(poe)
  );

  always @(negedge clk) if (rst_n && rx_valid) vcount++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt_ref(int s, int g, int w, bit se);
    int v;
    if (w == 1) begin
      v = s % 8192;
      v = se ? (v >= 4096 ? v - 8192 : v) : v * 8 + g;
    end else if (w == 2) begin
      v = s % 256;
      v = se ? (v >= 128 ? v - 256 : v) : v * 256;
    end else v = s;
    return 16'(v);
  endfunction

  function automatic logic [15:0] rx_ref(int s, int w);
    int v;
    if (w == 1) begin v = s % 8192; if (v >= 4096) v -= 8192; end
    else if (w == 2) begin v = s % 256; if (v >= 128) v -= 256; end
    else v = s;
    return 16'(v);
  endfunction

  task automatic step(input int p);
    bclk = 1'b1; din = din_at[p];
    repeat (6) @(negedge clk);
    out_r[p] = pout; oe_r[p] = poe;
    repeat (2) @(negedge clk);
    bclk = 1'b0; sync = sync_at[p];
    repeat (6) @(negedge clk);
    oe_f[p] = poe;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_sched();
    for (int p = 0; p < 64; p++) begin sync_at[p] = 1'b0; din_at[p] = 1'b0; end
  endtask

  // frame start detected at rising edge d
  task automatic sched(input int d, input logic [15:0] rxw);
    if (short_s) sync_at[d-2] = 1'b1;
    else for (int p = d - 1; p <= d + 3; p++) sync_at[p] = 1'b1;
    for (int i = 0; i < 16; i++) din_at[d+1+i] = lsb ? rxw[i] : rxw[15-i];
  endtask

  task automatic check_tx(input int d, input logic [15:0] txw, input string req);
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      logic e;
      e = mute ? 1'b0 : (lsb ? txw[i] : txw[15-i]);
      if (out_r[d+1+i] !== e) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic one_frame(input int ts, input int rs, input int g);
    int d = 4, v0;
    logic [15:0] txw, rxw, erx;
    string treq;
    tx_s = 16'(ts); gain = 3'(g);
    txw = fmt_ref(ts, g, width, sext);
    rxw = fmt_ref(rs, g, width, sext);
    erx = rx_ref(rs, width);
    clear_sched();
    sched(d, rxw);
    v0 = vcount;
    for (int p = 0; p < d + 19; p++) step(p);
    treq = mute ? "R8" : (lsb ? "R5" : (sext ? "R4" : "R3"));
    check_tx(d, txw, treq);
    if (tri_en) begin
      chk(oe_r[d] == 1'b0 && oe_r[d+1] == 1'b1, slave ? "R2" : "R1", oe_r[d+1], 1);
      begin
        int bad = 0;
        for (int p = d + 1; p <= d + 16; p++) if (oe_r[p] !== 1'b1) bad++;
        for (int p = d + 1; p <= d + 15; p++) if (oe_f[p] !== 1'b1) bad++;
        chk(bad == 0, "R6", bad, 0);
      end
      chk(oe_f[d+16] == tri_late && oe_r[d+17] == 1'b0, "R7", {oe_f[d+16], oe_r[d+17]}, {tri_late, 1'b0});
    end else begin
      int bad = 0;
      for (int p = 0; p < d + 19; p++) if (oe_r[p] !== 1'b1 || oe_f[p] !== 1'b1) bad++;
      chk(bad == 0, "R6", bad, 0);
    end
    chk(out_r[d] == 1'b0 && out_r[d+17] == 1'b0, "R10", {out_r[d], out_r[d+17]}, 0);
    chk(rx_sample == erx, "R9", rx_sample, erx);
    chk(vcount - v0 == 1, "R9", vcount - v0, 1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(poe == 1'b0 && pout == 1'b0, "R6", {poe, pout}, 0);
    chk(rx_valid == 1'b0 && rx_sample == 16'h0, "R9", rx_sample, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // full sweep: width x fill x order x sync style
    for (int c = 0; c < 24; c++) begin
      width = 2'(c % 3); sext = (c / 3) % 2; lsb = (c / 6) % 2; short_s = (c / 12) % 2;
      slave = c % 2; tri_late = (c / 2) % 2;
      one_frame((c * 7919 + 40961) % 65536, (c * 4513 + 36000) % 65536, c % 8);
    end

    // mute keeps timing
    width = 2'd0; sext = 0; lsb = 0; short_s = 0; slave = 1; tri_late = 0; mute = 1;
    one_frame(16'hFFFF, 16'h5A3C, 0);
    mute = 0;

    // enable never released
    tri_en = 0; width = 2'd1; sext = 0; lsb = 1;
    one_frame(16'h1ABC, 16'h0F0F, 5);
    tri_en = 1; lsb = 0;

    // back-to-back slots: enable held across the boundary
    begin
      logic [15:0] txw, rxw;
      int v0;
      width = 2'd0; sext = 0; short_s = 0; tri_late = 0;
      tx_s = 16'hC3A5; txw = 16'hC3A5; rxw = 16'h8E71;
      clear_sched();
      sched(4, rxw);
      sched(20, rxw);
      v0 = vcount;
      for (int p = 0; p < 42; p++) step(p);
      check_tx(4, txw, "R2");
      check_tx(20, txw, "R2");
      chk(oe_f[20] == 1'b1 && oe_r[21] == 1'b1, "R7", {oe_f[20], oe_r[21]}, 3);
      chk(oe_f[36] == 1'b0, "R7", oe_f[36], 0);
      chk(vcount - v0 == 2 && rx_sample == rxw, "R9", rx_sample, rxw);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule